// File: doc/BRIEF.md
# 16-bit Arithmetic-Logic Unit with Wide Multiply and Shift Carries

This block computes a 16-bit result from two operands and a 5-bit operation code in the same cycle the inputs are presented. It covers addition, subtraction, both halves of an unsigned 16x16 product, six bitwise logic functions, one-position shifts and zero-filling barrel shifts. The result path is purely combinational, so a surrounding datapath can use it within one cycle.

Status is kept in a 7-bit flag register that branch-condition logic reads. The register is written on a rising clock edge only while the flag-write enable is high and the opcode is a defined one. Each flag is written only by the operations that define it; all others keep their value. The unsigned comparison flags are rewritten by every flag-writing operation. The reset input clears the flags at once, and its release is synchronised to the clock inside the block.

Top module: `mdalu_top`

## Requirements
- R1: Opcode 0 (add) gives result (A+B) mod 65536; on a flag write it sets flag bit 0 (carry) to bit 16 of the 17-bit sum.
- R2: Opcode 1 (subtract) gives result (A-B) mod 65536; on a flag write it sets flag bit 0 (carry) to 1 when A >= B unsigned (no borrow), else 0.
- R3: Opcode 2 gives bits 15:0 and opcode 3 gives bits 31:16 of the unsigned 32-bit product A*B; on a flag write either opcode sets flag bit 6 (multiply overflow) to 1 exactly when the product is 65536 or more.
- R4: Opcodes 4..9 give A&B, A|B, A^B, ~(A&B), ~(A|B) and ~(A^B) in that order.
- R5: Opcode 10 shifts A right by one and opcode 11 shifts A left by one, filling with zero; on a flag write the bit shifted out goes to flag bit 4 (right-shift carry) or flag bit 5 (left-shift carry) respectively.
- R6: Opcode 12 shifts A right and opcode 13 shifts A left by B[3:0] positions, filling with zeros; B[15:4] has no effect.
- R7: Every flag write with a defined opcode sets exactly one of flag bit 1 (A > B), bit 2 (A < B) and bit 3 (A == B), all unsigned.
- R8: Flags change only on a rising edge while the write enable is high; a flag that the current operation does not define keeps its value.
- R9: Opcodes 14..31 give result 0 and leave every flag unchanged even with the write enable high.
- R10: A low reset input clears all seven flags immediately, without waiting for a clock edge; flag writes resume two clock edges after the reset input goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| opcode | input | 5 | Operation select |
| flag_we | input | 1 | Flag register write enable |
| result | output | 16 | Combinational result |
| flags | output | 7 | Flag register: bit0 carry, bit1 gt, bit2 lt, bit3 eq, bit4 right-shift carry, bit5 left-shift carry, bit6 multiply overflow |

## Verification
The assertions watch the flag register on every clock: it holds still without a write, keeps its value for undefined opcodes, carries exactly one comparison flag after each defined write, and records the multiply overflow and the shift-out bits of the one-position shifts. The arithmetic, logic and barrel-shift results, the carry meaning for add and subtract, the effect of B's upper bits on barrel shifts and the immediate clearing on reset are shown only by the bench's directed scenarios, which compare against values it computes from the operands.

// File: rtl/mdalu_pkg.sv
package mdalu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_MULLO = 5'd2,
    OP_MULHI = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NAND  = 5'd7,
    OP_NOR   = 5'd8,
    OP_XNOR  = 5'd9,
    OP_SHR1  = 5'd10,
    OP_SHL1  = 5'd11,
    OP_BSHR  = 5'd12,
    OP_BSHL  = 5'd13
  } alu_op_e;

  localparam logic [4:0] OP_LAST = 5'd13;

  // packed so that carry lands on bit 0 and mul_ovf on bit 6
  typedef struct packed {
    logic mul_ovf;
    logic sl_carry;
    logic sr_carry;
    logic eq;
    logic lt;
    logic gt;
    logic carry;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/mdalu_rst_sync.sv
module mdalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mdalu_arith.sv
module mdalu_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sum_carry,
  output logic [W-1:0] diff,
  output logic         no_borrow,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi
);

  localparam int PW = 2 * W;

  logic [W:0]    sum_ext;
  logic [W:0]    diff_ext;
  logic [PW-1:0] prod_full;

  always_comb begin
    sum_ext   = {1'b0, a} + {1'b0, b};
    diff_ext  = {1'b0, a} - {1'b0, b};
    prod_full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    sum       = sum_ext[W-1:0];
    sum_carry = sum_ext[W];
    diff      = diff_ext[W-1:0];
    no_borrow = ~diff_ext[W];
    prod_lo   = prod_full[W-1:0];
    prod_hi   = prod_full[PW-1:W];
  end

endmodule

// File: rtl/mdalu_shift.sv
module mdalu_shift #(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   shr1,
  output logic           shr1_out,
  output logic [W-1:0]   shl1,
  output logic           shl1_out,
  output logic [W-1:0]   bshr,
  output logic [W-1:0]   bshl
);

  logic [W-1:0] rstg [0:SHW];
  logic [W-1:0] lstg [0:SHW];

  assign rstg[0] = a;
  assign lstg[0] = a;

  // one stage per shift-amount bit, stage s moves by 2**s
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign rstg[s+1] = amt[s] ? (rstg[s] >> (1 << s)) : rstg[s];
    assign lstg[s+1] = amt[s] ? (lstg[s] << (1 << s)) : lstg[s];
  end

  always_comb begin
    shr1     = {1'b0, a[W-1:1]};
    shr1_out = a[0];
    shl1     = {a[W-2:0], 1'b0};
    shl1_out = a[W-1];
    bshr     = rstg[SHW];
    bshl     = lstg[SHW];
  end

endmodule

// File: rtl/mdalu_flag_reg.sv
module mdalu_flag_reg
  import mdalu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  alu_flags_t d,
  output alu_flags_t q
);

  alu_flags_t q_r;
  alu_flags_t q_nxt;

  always_comb begin
    q_nxt = en ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  assert_hold_no_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_r));

endmodule

// File: rtl/mdalu_top.sv
module mdalu_top
  import mdalu_pkg::*;
#(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [4:0]        opcode,
  input  logic              flag_we,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags
);

  logic         rst_sync_n;
  logic [W-1:0] sum, diff, prod_lo, prod_hi;
  logic         sum_carry, no_borrow;
  logic [W-1:0] shr1, shl1, bshr, bshl;
  logic         shr1_out, shl1_out;
  logic         op_valid;
  logic         flag_en;
  alu_flags_t   flag_q;
  alu_flags_t   flag_d;

  mdalu_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdalu_arith #(.W(W)) arith_i (
    .a         (op_a),
    .b         (op_b),
    .sum       (sum),
    .sum_carry (sum_carry),
    .diff      (diff),
    .no_borrow (no_borrow),
    .prod_lo   (prod_lo),
    .prod_hi   (prod_hi)
  );

  mdalu_shift #(.W(W)) shift_i (
    .a        (op_a),
    .amt      (op_b[SHW-1:0]),
    .shr1     (shr1),
    .shr1_out (shr1_out),
    .shl1     (shl1),
    .shl1_out (shl1_out),
    .bshr     (bshr),
    .bshl     (bshl)
  );

  always_comb begin
    op_valid = (opcode <= OP_LAST);
    unique case (opcode)
      OP_ADD:   result = sum;
      OP_SUB:   result = diff;
      OP_MULLO: result = prod_lo;
      OP_MULHI: result = prod_hi;
      OP_AND:   result = op_a & op_b;
      OP_OR:    result = op_a | op_b;
      OP_XOR:   result = op_a ^ op_b;
      OP_NAND:  result = ~(op_a & op_b);
      OP_NOR:   result = ~(op_a | op_b);
      OP_XNOR:  result = ~(op_a ^ op_b);
      OP_SHR1:  result = shr1;
      OP_SHL1:  result = shl1;
      OP_BSHR:  result = bshr;
      OP_BSHL:  result = bshl;
      default:  result = '0;
    endcase
  end

  // flag next state: only the flags an operation defines are replaced
  always_comb begin
    flag_d    = flag_q;
    flag_d.gt = (op_a > op_b);
    flag_d.lt = (op_a < op_b);
    flag_d.eq = (op_a == op_b);
    case (opcode)
      OP_ADD:            flag_d.carry    = sum_carry;
      OP_SUB:            flag_d.carry    = no_borrow;
      OP_MULLO, OP_MULHI: flag_d.mul_ovf = (prod_hi != '0);
      OP_SHR1:           flag_d.sr_carry = shr1_out;
      OP_SHL1:           flag_d.sl_carry = shl1_out;
      default:           flag_d.carry    = flag_q.carry;
    endcase
    flag_en = flag_we & op_valid;
  end

  mdalu_flag_reg flag_reg_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (flag_en),
    .d     (flag_d),
    .q     (flag_q)
  );

  assign flags = flag_q;

  assert_unused_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_we && (opcode > OP_LAST)) |=> (flags == $past(flags)));

  assert_cmp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_we && op_valid) |=> ($countones(flags[3:1]) == 1));

  assert_mul_ovf_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_we && (opcode == OP_MULLO || opcode == OP_MULHI))
      |=> (flags[6] == ($past(prod_hi) != '0)));

  assert_shl_carry_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_we && opcode == OP_SHL1) |=> (flags[5] == $past(op_a[W-1])));

  assert_shr_carry_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_we && opcode == OP_SHR1) |=> (flags[4] == $past(op_a[0])));

  always_comb begin
    if (rst_sync_n && opcode > OP_LAST)
      assert_unused_zero_R9: assert (result == '0);
  end

endmodule

// File: tb/mdalu_top_tb_top.sv
module mdalu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [4:0]  opcode;
  logic        flag_we;
  logic [15:0] result;
  logic [6:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_flags;

  always #2.5 clk = ~clk;

  mdalu_top dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .opcode  (opcode),
    .flag_we (flag_we),
    .result  (result),
    .flags   (flags)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_res(logic [4:0] op, logic [15:0] a, logic [15:0] b);
    logic [31:0] p;
    p = 32'(a) * 32'(b);
    case (op)
      5'd0:  return a + b;
      5'd1:  return a - b;
      5'd2:  return p[15:0];
      5'd3:  return p[31:16];
      5'd4:  return a & b;
      5'd5:  return a | b;
      5'd6:  return a ^ b;
      5'd7:  return ~(a & b);
      5'd8:  return ~(a | b);
      5'd9:  return ~(a ^ b);
      5'd10: return a >> 1;
      5'd11: return a << 1;
      5'd12: return a >> b[3:0];
      5'd13: return a << b[3:0];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [6:0] model_flags(logic [6:0] f, logic [4:0] op,
                                             logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    logic [31:0] p;
    if (op > 5'd13) return f;
    s = 17'(a) + 17'(b);
    p = 32'(a) * 32'(b);
    f[1] = a > b;
    f[2] = a < b;
    f[3] = a == b;
    if (op == 5'd0) f[0] = s[16];
    if (op == 5'd1) f[0] = (a >= b);
    if (op == 5'd2 || op == 5'd3) f[6] = (p > 32'hFFFF);
    if (op == 5'd10) f[4] = a[0];
    if (op == 5'd11) f[5] = a[15];
    return f;
  endfunction

  // drive one operation, check the result, then the flags after the edge
  task automatic do_op(string req, logic [4:0] op, logic [15:0] a,
                       logic [15:0] b, logic we);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; flag_we = we;
    #1;
    check(req, 32'(result), 32'(model_res(op, a, b)));
    if (we) exp_flags = model_flags(exp_flags, op, a, b);
    @(posedge clk);
    #1;
    flag_we = 1'b0;
    #1;
    check(req, 32'(flags), 32'(exp_flags));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_a = '0; op_b = '0; opcode = '0; flag_we = 1'b0;
    exp_flags = '0;
    repeat (3) @(posedge clk);
    #1 check("R10 flags in reset", 32'(flags), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 flags after release", 32'(flags), 32'h0);
  endtask

  task automatic t_add;
    do_op("R1 add no carry", 5'd0, 16'h1234, 16'h0101, 1'b1);
    do_op("R1 add carry",    5'd0, 16'hFFFF, 16'h0001, 1'b1);
    do_op("R1 add max",      5'd0, 16'h8000, 16'h8000, 1'b1);
  endtask

  task automatic t_sub;
    do_op("R2 sub equal",  5'd1, 16'h5555, 16'h5555, 1'b1);
    do_op("R2 sub borrow", 5'd1, 16'h0003, 16'h0004, 1'b1);
    do_op("R2 sub big",    5'd1, 16'hF000, 16'h0FFF, 1'b1);
  endtask

  task automatic t_mul;
    do_op("R3 mullo small", 5'd2, 16'h00FF, 16'h0100, 1'b1);
    do_op("R3 mullo ovf",   5'd2, 16'h0100, 16'h0100, 1'b1);
    do_op("R3 mulhi max",   5'd3, 16'hFFFF, 16'hFFFF, 1'b1);
    do_op("R3 mulhi no ovf",5'd3, 16'h00FF, 16'h00FF, 1'b1);
  endtask

  task automatic t_logic;
    for (int op = 4; op <= 9; op++) begin
      do_op("R4 logic", 5'(op), 16'hF0CC, 16'hAA0F, 1'b1);
      do_op("R4 logic", 5'(op), 16'h0000, 16'hFFFF, 1'b1);
    end
  endtask

  task automatic t_shift1;
    do_op("R5 shr1 out one",  5'd10, 16'h8001, 16'h0000, 1'b1);
    do_op("R5 shl1 out one",  5'd11, 16'h8001, 16'h0000, 1'b1);
    do_op("R5 shr1 out zero", 5'd10, 16'h7FFE, 16'h0000, 1'b1);
    do_op("R5 shl1 out zero", 5'd11, 16'h7FFE, 16'h0000, 1'b1);
  endtask

  task automatic t_barrel;
    do_op("R6 bshr 0",     5'd12, 16'hBEEF, 16'h0000, 1'b1);
    do_op("R6 bshr 15",    5'd12, 16'h8000, 16'h000F, 1'b1);
    do_op("R6 bshl 7",     5'd13, 16'h00F3, 16'h0007, 1'b1);
    do_op("R6 bshl upper", 5'd13, 16'h1234, 16'hFFF4, 1'b1);
    do_op("R6 bshr upper", 5'd12, 16'h1234, 16'h0010, 1'b1);
  endtask

  task automatic t_cmp;
    do_op("R7 gt", 5'd4, 16'h8000, 16'h7FFF, 1'b1);
    do_op("R7 lt", 5'd5, 16'h0001, 16'hFFFF, 1'b1);
    do_op("R7 eq", 5'd6, 16'hABCD, 16'hABCD, 1'b1);
  endtask

  task automatic t_no_we;
    do_op("R8 setup", 5'd0, 16'hFFFF, 16'hFFFF, 1'b1);
    do_op("R8 no write add", 5'd0, 16'h0001, 16'h0001, 1'b0);
    do_op("R8 no write sub", 5'd1, 16'h0000, 16'h0009, 1'b0);
    do_op("R8 logic keeps carry", 5'd8, 16'h0000, 16'h0000, 1'b1);
  endtask

  task automatic t_unused;
    do_op("R9 setup", 5'd11, 16'h8000, 16'h0001, 1'b1);
    do_op("R9 op14", 5'd14, 16'hFFFF, 16'h0001, 1'b1);
    do_op("R9 op20", 5'd20, 16'h0000, 16'h1234, 1'b1);
    do_op("R9 op31", 5'd31, 16'h4444, 16'h4444, 1'b1);
  endtask

  task automatic t_async_reset;
    do_op("R10 setup", 5'd3, 16'hFFFF, 16'hFFFF, 1'b1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    exp_flags = '0;
    check("R10 async clear", 32'(flags), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 after async release", 32'(flags), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_mul();
    t_logic();
    t_shift1();
    t_barrel();
    t_cmp();
    t_no_we();
    t_unused();
    t_async_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule